// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level short-format translation table held in memory. A requester presents the address, the kind of access (read, write or instruction fetch) and whether it runs in user mode. The walker fetches the first-level descriptor and, when that descriptor points to a second-level table, the second-level descriptor too. It uses a memory read port that carries one read at a time. It answers with a one-cycle `done` pulse that carries either a physical address with permission information or a fault with a status code.

The table base, the domain access control word, and the privileged-execute-never enables are inputs. They must stay stable while a walk is in flight. When either `cfg_pxn_on` or `cfg_lpa_on` is high, the privileged-execute-never feature is active. The walker then accepts the otherwise reserved level-1 kind 3 as a section, and honours a privileged-execute-never bit. That bit sits at a different position in a section descriptor than in a page-table descriptor.

The controller has six states. ST_IDLE waits for a request and moves to ST_L1_RD on `req_valid`. ST_L1_RD holds the level-1 read until `mem_ack` and then moves to ST_L1_CHK. ST_L1_CHK decodes the descriptor and either moves to ST_L2_RD for a page-table descriptor that passed the domain check, or moves to ST_DONE with a result. ST_L2_RD holds the level-2 read until `mem_ack` and then moves to ST_L2_CHK. ST_L2_CHK always moves to ST_DONE. ST_DONE pulses `done` and returns to ST_IDLE.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle, and it is high during reset. A request is accepted on the edge where `req_valid` and `req_ready` are both high. The first read then goes to address {cfg_base[31:14], va[31:20], 2'b00}. Access kind encoding: 0 read, 1 write, 2 instruction fetch, 3 behaves as read.
- R2: A level-1 descriptor with bits [1:0] = 0 faults with code 5. Bits [1:0] = 3 also faults with code 5 while the feature is inactive. In both cases no second read is made.
- R3: The feature is active when `cfg_pxn_on` or `cfg_lpa_on` is high. Kind 3 is then a section whose privileged-execute-never bit is desc[0]. Kind 2 is a section as well.
- R4: A descriptor that is not a page table (kind 1) and has bit 18 set is a supersection and uses domain 0. Every other descriptor takes its domain from bits [8:5]. The domain's 2-bit access value sits at bit 2×domain of `cfg_dom`.
- R5: An access value of 0 or 2 is a domain fault. The code is 9 for a section or supersection and 11 for a page-table descriptor. No second read is made.
- R6: A section gives pa = {desc[31:20], va[19:0]}. A supersection gives pa = {desc[31:24], va[23:0]}. Both give perm_ap = {desc[15], desc[11:10]} and execute-never desc[4].
- R7: For a page-table descriptor, the second read goes to {desc[31:10], va[19:12], 2'b00}. Its privileged-execute-never bit is desc[2], and it counts only while the feature is active.
- R8: A level-2 descriptor with bit 1 clear (bits [1:0] = 00 or 01) faults with code 7. Otherwise it is a small page: pa = {desc[31:12], va[11:0]}, perm_ap = {desc[9], desc[5:4]}, execute-never desc[0].
- R9: An access value of 3 (manager) never faults. It reports `dom_mgr` = 1 and `perm_xn` = 0.
- R10: For a client domain, the effective execute-never is the descriptor's execute-never OR (privileged-execute-never AND not user). It is reported on `perm_xn`. An instruction fetch with effective execute-never set faults with code 13 at a section and code 15 at a small page. Reads and writes are not refused.
- R11: `done` is high for exactly one cycle. It rises on the edge after the edge that samples the last `mem_ack` of the walk.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. At most one read is outstanding, and no read is requested while idle.
- R13: With `done` high and `fault` low, `fault_code` is 0. With `fault` high, `pa`, `perm_ap`, `perm_xn` and `dom_mgr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| cfg_base | input | 32 | Level-1 table base (bits 31:14 used) |
| cfg_dom | input | 32 | Domain access word, 2 bits per domain |
| cfg_pxn_on | input | 1 | Enable privileged-execute-never |
| cfg_lpa_on | input | 1 | Large-physical-address mode, forces the feature on |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Translation refused |
| fault_code | output | 4 | Status code (0 when no fault) |
| pa | output | 32 | Physical address |
| perm_ap | output | 3 | Access permission bits |
| perm_xn | output | 1 | Effective execute-never for the requesting mode |
| dom_mgr | output | 1 | Domain is manager |

## Verification
Let L be the number of idle cycles the memory model inserts before it acks a read. With that, the first read appears on the edge that accepts the request, and a result decided at level 1 raises `done` after the edge L+2 past the acceptance edge. A two-level walk raises it after edge 2L+4. The bench works out this edge count from its own model for each request and compares `done`, `req_ready` and the result fields at every negative edge. `done` must be low before the computed edge, high with the expected fields on it, and low with `req_ready` high one cycle later. The memory model also checks each read address at the moment it acks, and counts the reads, so that a walk ending at level 1 is seen to make no second read.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XW        = 32;
    localparam int BASE_LSB  = 14;
    localparam int SEC_LSB   = 20;
    localparam int SUP_LSB   = 24;
    localparam int PAGE_LSB  = 12;
    localparam int TAB_LSB   = 10;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_IF  = 2'd2,
        ACC_RSV = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        DOM_NONE   = 2'd0,
        DOM_CLIENT = 2'd1,
        DOM_RSV    = 2'd2,
        DOM_MGR    = 2'd3
    } dom_acc_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_L1_RD  = 3'd1,
        ST_L1_CHK = 3'd2,
        ST_L2_RD  = 3'd3,
        ST_L2_CHK = 3'd4,
        ST_DONE   = 3'd5
    } walk_state_e;

    localparam logic [3:0] FC_NONE     = 4'd0;
    localparam logic [3:0] FC_L1_XLAT  = 4'd5;
    localparam logic [3:0] FC_L2_XLAT  = 4'd7;
    localparam logic [3:0] FC_DOM_SEC  = 4'd9;
    localparam logic [3:0] FC_DOM_PAGE = 4'd11;
    localparam logic [3:0] FC_PRM_SEC  = 4'd13;
    localparam logic [3:0] FC_PRM_PAGE = 4'd15;

    typedef struct packed {
        logic          fault;
        logic [3:0]    code;
        logic [XW-1:0] pa;
        logic [2:0]    ap;
        logic          xn;
        logic          mgr;
    } xlat_res_t;

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
    import xlat_pkg::*;
(
    input  logic [XW-1:0] desc,
    input  logic [XW-1:0] va,
    input  logic          feat_pxn,
    output logic          bad,
    output logic          is_table,
    output logic [3:0]    domain,
    output logic [XW-1:0] sec_pa,
    output logic [2:0]    sec_ap,
    output logic          sec_xn,
    output logic          sec_pxn,
    output logic          tab_pxn,
    output logic [XW-1:0] l2_addr
);
    logic [1:0] kind;
    logic       is_super;
    logic       unused_l1;

    always_comb begin
        kind     = desc[1:0];
        bad      = (kind == 2'd0) || ((kind == 2'd3) && !feat_pxn);
        is_table = (kind == 2'd1);
        is_super = !is_table && desc[18];
        domain   = is_super ? 4'd0 : desc[8:5];
        if (is_super) begin
            sec_pa = {desc[XW-1:SUP_LSB], va[SUP_LSB-1:0]};
        end else begin
            sec_pa = {desc[XW-1:SEC_LSB], va[SEC_LSB-1:0]};
        end
        sec_ap  = {desc[15], desc[11:10]};
        sec_xn  = desc[4];
        sec_pxn = desc[0];
        tab_pxn = feat_pxn & desc[2];
        l2_addr = {desc[XW-1:TAB_LSB], va[SEC_LSB-1:PAGE_LSB], 2'b00};
    end

    assign unused_l1 = ^{desc[19], desc[17:16], desc[14:12], desc[9], desc[3],
                         va[XW-1:SUP_LSB]};
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
    import xlat_pkg::*;
(
    input  logic [XW-1:0] desc,
    input  logic [XW-1:0] va,
    output logic          bad,
    output logic [XW-1:0] pg_pa,
    output logic [2:0]    pg_ap,
    output logic          pg_xn
);
    logic unused_l2;

    always_comb begin
        bad   = !desc[1];
        pg_pa = {desc[XW-1:PAGE_LSB], va[PAGE_LSB-1:0]};
        pg_ap = {desc[9], desc[5:4]};
        pg_xn = desc[0];
    end

    assign unused_l2 = ^{desc[11:10], desc[8:6], desc[3:2], va[XW-1:PAGE_LSB]};
endmodule

// File: rtl/xlat_dom_lookup.sv
module xlat_dom_lookup
    import xlat_pkg::*;
#(
    parameter int DOM_COUNT = 16,
    localparam int DOM_IDX_W = $clog2(DOM_COUNT)
) (
    input  logic [2*DOM_COUNT-1:0] dacr,
    input  logic [DOM_IDX_W-1:0]   idx,
    output dom_acc_e               acc
);
    logic [1:0] field [DOM_COUNT];

    for (genvar g = 0; g < DOM_COUNT; g++) begin : g_field
        assign field[g] = dacr[2*g +: 2];
    end

    assign acc = dom_acc_e'(field[idx]);
endmodule

// File: rtl/xlat_exec_guard.sv
module xlat_exec_guard
    import xlat_pkg::*;
(
    input  logic      xn,
    input  logic      pxn,
    input  logic      user,
    input  acc_kind_e kind,
    input  logic      mgr,
    output logic      xn_eff,
    output logic      deny
);
    always_comb begin
        xn_eff = !mgr && (xn || (pxn && !user));
        deny   = (kind == ACC_IF) && xn_eff;
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int DOM_COUNT = 16,
    localparam int DOM_IDX_W = $clog2(DOM_COUNT),
    localparam int STAGES    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [XW-1:0]          req_va,
    input  logic [1:0]             req_kind,
    input  logic                   req_user,
    input  logic [XW-1:0]          cfg_base,
    input  logic [2*DOM_COUNT-1:0] cfg_dom,
    input  logic                   cfg_pxn_on,
    input  logic                   cfg_lpa_on,
    output logic                   mem_req,
    output logic [XW-1:0]          mem_addr,
    input  logic                   mem_ack,
    input  logic [XW-1:0]          mem_rdata,
    output logic                   done,
    output logic                   fault,
    output logic [3:0]             fault_code,
    output logic [XW-1:0]          pa,
    output logic [2:0]             perm_ap,
    output logic                   perm_xn,
    output logic                   dom_mgr
);
    walk_state_e state_q, state_d;

    logic [XW-1:0] va_q, d1_q, d2_q;
    acc_kind_e     kind_q;
    logic          user_q, tpxn_q, mgr_q;
    xlat_res_t     res_q, res_d;

    logic          feat_pxn;
    logic [XW-1:0] l1_addr;
    logic          unused_base;

    logic          l1_bad, l1_table, l1_sxn, l1_spxn, l1_tpxn;
    logic [3:0]    l1_dom;
    logic [XW-1:0] l1_spa, l1_l2addr;
    logic [2:0]    l1_sap;
    dom_acc_e      dom_acc;
    logic          dom_block, dom_is_mgr;

    logic          l2_bad, l2_xn;
    logic [XW-1:0] l2_pa;
    logic [2:0]    l2_ap;

    logic          g_xn   [STAGES];
    logic          g_pxn  [STAGES];
    logic          g_mgr  [STAGES];
    logic          g_eff  [STAGES];
    logic          g_deny [STAGES];

    assign feat_pxn    = cfg_pxn_on | cfg_lpa_on;
    assign l1_addr     = {cfg_base[XW-1:BASE_LSB], va_q[XW-1:SEC_LSB], 2'b00};
    assign unused_base = ^cfg_base[BASE_LSB-1:0];

    xlat_l1_decode u_l1 (
        .desc     (d1_q),
        .va       (va_q),
        .feat_pxn (feat_pxn),
        .bad      (l1_bad),
        .is_table (l1_table),
        .domain   (l1_dom),
        .sec_pa   (l1_spa),
        .sec_ap   (l1_sap),
        .sec_xn   (l1_sxn),
        .sec_pxn  (l1_spxn),
        .tab_pxn  (l1_tpxn),
        .l2_addr  (l1_l2addr)
    );

    xlat_dom_lookup #(.DOM_COUNT(DOM_COUNT)) u_dom (
        .dacr (cfg_dom),
        .idx  (l1_dom[DOM_IDX_W-1:0]),
        .acc  (dom_acc)
    );

    assign dom_block  = (dom_acc == DOM_NONE) || (dom_acc == DOM_RSV);
    assign dom_is_mgr = (dom_acc == DOM_MGR);

    xlat_l2_decode u_l2 (
        .desc  (d2_q),
        .va    (va_q),
        .bad   (l2_bad),
        .pg_pa (l2_pa),
        .pg_ap (l2_ap),
        .pg_xn (l2_xn)
    );

    // Stage 0 guards a section result, stage 1 a small page result.
    assign g_xn[0]  = l1_sxn;
    assign g_pxn[0] = l1_spxn;
    assign g_mgr[0] = dom_is_mgr;
    assign g_xn[1]  = l2_xn;
    assign g_pxn[1] = tpxn_q;
    assign g_mgr[1] = mgr_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_guard
        xlat_exec_guard u_guard (
            .xn     (g_xn[s]),
            .pxn    (g_pxn[s]),
            .user   (user_q),
            .kind   (kind_q),
            .mgr    (g_mgr[s]),
            .xn_eff (g_eff[s]),
            .deny   (g_deny[s])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_L1_RD;
            ST_L1_RD:  if (mem_ack)   state_d = ST_L1_CHK;
            ST_L1_CHK: begin
                if (!l1_bad && !dom_block && l1_table) begin
                    state_d = ST_L2_RD;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_L2_RD:  if (mem_ack)   state_d = ST_L2_CHK;
            ST_L2_CHK: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Result formation in the two check states
    always_comb begin
        res_d = '0;
        unique case (state_q)
            ST_L1_CHK: begin
                if (l1_bad) begin
                    res_d.fault = 1'b1;
                    res_d.code  = FC_L1_XLAT;
                end else if (dom_block) begin
                    res_d.fault = 1'b1;
                    res_d.code  = l1_table ? FC_DOM_PAGE : FC_DOM_SEC;
                end else if (!l1_table) begin
                    if (g_deny[0]) begin
                        res_d.fault = 1'b1;
                        res_d.code  = FC_PRM_SEC;
                    end else begin
                        res_d.pa  = l1_spa;
                        res_d.ap  = l1_sap;
                        res_d.xn  = g_eff[0];
                        res_d.mgr = dom_is_mgr;
                    end
                end
            end
            ST_L2_CHK: begin
                if (l2_bad) begin
                    res_d.fault = 1'b1;
                    res_d.code  = FC_L2_XLAT;
                end else if (g_deny[1]) begin
                    res_d.fault = 1'b1;
                    res_d.code  = FC_PRM_PAGE;
                end else begin
                    res_d.pa  = l2_pa;
                    res_d.ap  = l2_ap;
                    res_d.xn  = g_eff[1];
                    res_d.mgr = mgr_q;
                end
            end
            default: res_d = '0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            kind_q <= ACC_RD;
            user_q <= 1'b0;
            d1_q   <= '0;
            d2_q   <= '0;
            tpxn_q <= 1'b0;
            mgr_q  <= 1'b0;
            res_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                va_q   <= req_va;
                kind_q <= acc_kind_e'(req_kind);
                user_q <= req_user;
            end
            if ((state_q == ST_L1_RD) && mem_ack) begin
                d1_q <= mem_rdata;
            end
            if ((state_q == ST_L2_RD) && mem_ack) begin
                d2_q <= mem_rdata;
            end
            if (state_q == ST_L1_CHK) begin
                tpxn_q <= l1_tpxn;
                mgr_q  <= dom_is_mgr;
            end
            if ((state_q == ST_L1_CHK) || (state_q == ST_L2_CHK)) begin
                res_q <= res_d;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_req    = 1'b0;
        mem_addr   = '0;
        done       = (state_q == ST_DONE);
        unique case (state_q)
            ST_L1_RD: begin
                mem_req  = 1'b1;
                mem_addr = l1_addr;
            end
            ST_L2_RD: begin
                mem_req  = 1'b1;
                mem_addr = l1_l2addr;
            end
            default: begin
                mem_req  = 1'b0;
                mem_addr = '0;
            end
        endcase
        fault      = res_q.fault;
        fault_code = res_q.code;
        pa         = res_q.pa;
        perm_ap    = res_q.ap;
        perm_xn    = res_q.xn;
        dom_mgr    = res_q.mgr;
    end
endmodule

// File: rtl/xlat_walker_sva.sv
module xlat_walker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [3:0]  fault_code,
    input logic [31:0] pa,
    input logic [2:0]  perm_ap,
    input logic        perm_xn,
    input logic        dom_mgr
);
    assert_idle_no_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!mem_req));

    assert_fault_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa == 32'd0 && perm_ap == 3'd0 && !perm_xn && !dom_mgr));

    assert_ok_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fault_code == 4'd0));

    assert_code_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code == 4'd5 || fault_code == 4'd7 ||
                             fault_code == 4'd9 || fault_code == 4'd11 ||
                             fault_code == 4'd13 || fault_code == 4'd15));

    assert_manager_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dom_mgr) |-> (!fault && !perm_xn));
endmodule

bind xlat_walker xlat_walker_sva u_xlat_walker_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .pa         (pa),
    .perm_ap    (perm_ap),
    .perm_xn    (perm_xn),
    .dom_mgr    (dom_mgr)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] cfg_base = 32'h0004_0000;
    logic [31:0] cfg_dom  = 32'h0000_048D;
    logic        cfg_pxn_on = 1'b0;
    logic        cfg_lpa_on = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, perm_xn, dom_mgr;
    logic [3:0]  fault_code;
    logic [31:0] pa;
    logic [2:0]  perm_ap;

    always #4 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_kind(req_kind), .req_user(req_user),
        .cfg_base(cfg_base), .cfg_dom(cfg_dom), .cfg_pxn_on(cfg_pxn_on),
        .cfg_lpa_on(cfg_lpa_on), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_code(fault_code), .pa(pa), .perm_ap(perm_ap), .perm_xn(perm_xn),
        .dom_mgr(dom_mgr)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem_img [bit [31:0]];

    // expected outcome of the current request
    bit          e_fault, e_xn, e_mgr;
    logic [3:0]  e_code;
    logic [31:0] e_pa, e_l1a, e_l2a;
    logic [2:0]  e_ap;
    int          e_cyc, e_reads;
    int          mem_lat = 0;
    int          wcnt = 0;
    int          nreads = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] l1_of(input logic [31:0] va);
        return {cfg_base[31:14], va[31:20], 2'b00};
    endfunction

    task automatic put_l1(input logic [31:0] va, input logic [31:0] d);
        mem_img[l1_of(va)] = d;
    endtask

    task automatic put_l2(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2);
        mem_img[{d1[31:10], va[19:12], 2'b00}] = d2;
    endtask

    // Reference model built from the requirements
    task automatic model(input logic [31:0] va, input logic [1:0] kind, input bit user, input int lat);
        logic [31:0] d1, d2;
        int k, dom, dv;
        bit feat, sup, x, p, eff, fetch;
        feat  = cfg_pxn_on || cfg_lpa_on;
        fetch = (kind == 2'd2);
        e_fault = 0; e_code = 0; e_pa = 0; e_ap = 0; e_xn = 0; e_mgr = 0;
        e_l1a = l1_of(va); e_l2a = 0; e_cyc = 2 + lat; e_reads = 1;
        d1 = rd(e_l1a);
        k = int'(d1[1:0]);
        if (k == 0 || (k == 3 && !feat)) begin
            e_fault = 1; e_code = 4'd5; return;
        end
        sup = (k != 1) && d1[18];
        dom = sup ? 0 : int'(d1[8:5]);
        dv  = int'((cfg_dom >> (2 * dom)) & 32'd3);
        if (dv == 0 || dv == 2) begin
            e_fault = 1; e_code = (k == 1) ? 4'd11 : 4'd9; return;
        end
        if (k != 1) begin
            x = d1[4]; p = d1[0];
            eff = x || (p && !user);
            if (dv == 3) begin
                e_mgr = 1; eff = 0;
            end else if (fetch && eff) begin
                e_fault = 1; e_code = 4'd13; return;
            end
            e_pa = sup ? {d1[31:24], va[23:0]} : {d1[31:20], va[19:0]};
            e_ap = {d1[15], d1[11:10]};
            e_xn = eff;
            return;
        end
        p = feat && d1[2];
        e_l2a = {d1[31:10], va[19:12], 2'b00};
        e_cyc = 4 + 2 * lat; e_reads = 2;
        d2 = rd(e_l2a);
        if (!d2[1]) begin
            e_fault = 1; e_code = 4'd7; return;
        end
        x = d2[0];
        eff = x || (p && !user);
        if (dv == 3) begin
            e_mgr = 1; eff = 0;
        end else if (fetch && eff) begin
            e_fault = 1; e_code = 4'd15; return;
        end
        e_pa = {d2[31:12], va[11:0]};
        e_ap = {d2[9], d2[5:4]};
        e_xn = eff;
    endtask

    // Memory responder: acks after mem_lat waiting cycles, checks addresses
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 0; wcnt = 0;
            end else if (mem_ack) begin
                mem_ack = 0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= mem_lat) begin
                    nreads++;
                    if (nreads == 1) chk(mem_addr == e_l1a, "R1", "l1 addr", mem_addr, e_l1a);
                    else             chk(mem_addr == e_l2a, "R7", "l2 addr", mem_addr, e_l2a);
                    mem_rdata = rd(mem_addr);
                    mem_ack = 1;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic run(input logic [31:0] va, input logic [1:0] kind, input bit user,
                       input int lat, input string rq);
        model(va, kind, user, lat);
        mem_lat = lat;
        nreads  = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready idle", 32'(req_ready), 32'd1);
        req_va = va; req_kind = kind; req_user = user; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0 && done == 1'b0, "R1", "busy after accept",
            {30'd0, req_ready, done}, 32'd0);
        for (int c = 1; c <= e_cyc; c++) begin
            @(negedge clk);
            if (c < e_cyc) begin
                chk(done == 1'b0, "R11", "early done", 32'(done), 32'd0);
            end else begin
                chk(done == 1'b1, "R11", "done due", 32'(done), 32'd1);
                chk(fault == e_fault, rq, "fault", 32'(fault), 32'(e_fault));
                chk(fault_code == e_code, rq, "code", 32'(fault_code), 32'(e_code));
                chk(pa == e_pa, rq, "pa", pa, e_pa);
                chk(perm_ap == e_ap, rq, "ap", 32'(perm_ap), 32'(e_ap));
                chk(perm_xn == e_xn, rq, "xn", 32'(perm_xn), 32'(e_xn));
                chk(dom_mgr == e_mgr, rq, "mgr", 32'(dom_mgr), 32'(e_mgr));
            end
        end
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11", "pulse end",
            {30'd0, done, req_ready}, 32'd1);
        chk(nreads == e_reads, "R12", "read count", 32'(nreads), 32'(e_reads));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0 && mem_req == 1'b0, "R12", "reset idle",
            {30'd0, done, mem_req}, 32'd0);
        rst_n = 1'b1;

        // R6: section, domain 5 client
        put_l1(32'h1234_5678, 32'hABC0_84A2);
        run(32'h1234_5678, 2'd0, 1'b0, 0, "R6");
        run(32'h1234_5678, 2'd1, 1'b1, 3, "R6");
        // R4: supersection ignores domain field (2 = no access), uses domain 0
        put_l1(32'h2345_6789, 32'h5604_8442);
        run(32'h2345_6789, 2'd0, 1'b0, 2, "R4");
        // R2: kind 0
        run(32'h3000_0000, 2'd0, 1'b0, 0, "R2");
        // R2/R3: kind 3 with feature off, then on
        put_l1(32'h4000_0000, 32'h7770_8403);
        run(32'h4000_0000, 2'd2, 1'b0, 1, "R2");
        cfg_pxn_on = 1'b1;
        run(32'h4000_0000, 2'd2, 1'b0, 0, "R10");
        run(32'h4000_0000, 2'd2, 1'b1, 0, "R10");
        cfg_pxn_on = 1'b0; cfg_lpa_on = 1'b1;
        run(32'h4000_0000, 2'd0, 1'b0, 0, "R3");
        cfg_lpa_on = 1'b0;
        // R5: section in no-access domain, page table in reserved domain
        put_l1(32'h5000_0000, 32'h5000_0042);
        run(32'h5000_0000, 2'd0, 1'b0, 0, "R5");
        put_l1(32'h6000_0000, 32'h0010_0461);
        run(32'h6000_0000, 2'd0, 1'b0, 1, "R5");
        // R9: manager section with xn
        put_l1(32'h7000_0000, 32'h7100_0032);
        run(32'h7000_0000, 2'd2, 1'b1, 0, "R9");
        // R10: client section with xn
        put_l1(32'h8000_0000, 32'h8100_0012);
        run(32'h8000_0000, 2'd2, 1'b1, 0, "R10");
        run(32'h8000_0000, 2'd0, 1'b1, 0, "R10");
        // R7/R8: small page walk
        put_l1(32'h9012_3456, 32'h0020_00A1);
        put_l2(32'h9012_3456, 32'h0020_00A1, 32'hCAFE_B222);
        run(32'h9012_3456, 2'd0, 1'b0, 1, "R8");
        run(32'h9012_3456, 2'd3, 1'b1, 2, "R8");
        // R7: level-1 pxn bit 2 honoured only with feature active
        put_l1(32'hA00A_B000, 32'h0030_00A5);
        put_l2(32'hA00A_B000, 32'h0030_00A5, 32'h1111_1002);
        cfg_pxn_on = 1'b1;
        run(32'hA00A_B000, 2'd2, 1'b0, 0, "R7");
        run(32'hA00A_B000, 2'd0, 1'b0, 0, "R7");
        cfg_pxn_on = 1'b0;
        run(32'hA00A_B000, 2'd2, 1'b0, 0, "R7");
        // R8: level-2 faults for 00 and 01
        put_l1(32'hB000_5000, 32'h0040_00A1);
        put_l2(32'hB000_5000, 32'h0040_00A1, 32'h0000_0000);
        run(32'hB000_5000, 2'd0, 1'b0, 0, "R8");
        put_l2(32'hB000_5000, 32'h0040_00A1, 32'h3333_0001);
        run(32'hB000_5000, 2'd0, 1'b0, 1, "R8");
        // R9/R10: manager page with xn, page xn under client
        put_l1(32'hC000_1000, 32'h0050_0021);
        put_l2(32'hC000_1000, 32'h0050_0021, 32'h2222_2003);
        run(32'hC000_1000, 2'd2, 1'b0, 0, "R9");
        put_l1(32'hD000_1000, 32'h0060_00A1);
        put_l2(32'hD000_1000, 32'h0060_00A1, 32'h4444_4003);
        run(32'hD000_1000, 2'd2, 1'b1, 0, "R10");
        run(32'hD000_1000, 2'd1, 1'b1, 0, "R13");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule